// File: doc/BRIEF.md
# Lockable Memory Configuration Register Bank

This block holds the configuration state for a set of on-chip RAM regions and is reached over a plain 32-bit register bus: a byte address, a write strobe, write data and combinational read data. Each region has four things here. There is a two-bit protection field with a fetch-block bit and a write-block bit. There is a two-bit test-mode field. There is a start bit that launches initialization. Finally, a completion flag comes in from outside and can be read back.

Writes to a region's configuration are guarded in three layers. The first is a soft lock that software can set and clear. The second is a commit bit that can only ever be set, and it holds until system reset. The third is a test-lock register that covers only the test-mode fields, and it changes only when a 16-bit key comes with the same write. A write that is blocked is dropped without any error. Read data always shows the value that is actually stored.

Top module: `memcfg_regbank`

## Requirements
- R1: After synchronous reset every stored field is 0. All outputs are 0, and every mapped register reads 0 apart from the completion mirror.
- R2: The soft-lock register sits at offset 0x00, with bit i for region i. While bit i is 1, writes to region i's protection, test-mode and start bits are dropped. While it is 0, they take effect.
- R3: The commit register sits at offset 0x04. Writing 1 to bit i sets it, and writing 0 never clears it. While it is set, region i's protection, test-mode and start bits are blocked whatever the soft lock holds. Only reset clears it.
- R4: The test-lock register sits at offset 0x18. Bits [N-1:0] update only when bits [31:16] of the same write equal 0xA5A5. Any other key leaves them unchanged, and bits [31:16] always read 0.
- R5: Test-lock bit i set to 1 blocks writes to region i's test-mode field only. The protection field stays writable.
- R6: The start register sits at offset 0x10. Writing 1 to bit i of an unblocked region raises init_start_o[i] for exactly the one cycle after the write edge. The register always reads 0.
- R7: Offset 0x14 reads back init_done_i. Writes to it have no effect.
- R8: Any address other than the seven mapped offsets reads 0 and ignores writes. Unused high bits of mapped registers read 0.
- R9: The protection field sits at offset 0x08: bit 2i blocks fetch and bit 2i+1 blocks writes for region i. The test-mode field sits at offset 0x0C, in bits [2i+1:2i]. One write updates the unblocked regions and leaves the blocked ones as they were, and readback shows the values actually stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| init_done_i | input | NUM_REGIONS | Per-region initialization complete flags |
| fetch_prot_o | output | NUM_REGIONS | Per-region fetch-block control |
| wr_prot_o | output | NUM_REGIONS | Per-region write-block control |
| test_mode_o | output | 2*NUM_REGIONS | Per-region two-bit test mode |
| init_start_o | output | NUM_REGIONS | One-cycle initialization start pulses |

## Verification
The bench builds the bank with NUM_REGIONS = 4. With four regions, one region can be free, one soft-locked, one committed and one test-locked all at the same moment. A single write to the protection or test-mode register then shows, in its readback, that each guard acts only on its own field slice. The expected values come from a small per-requirement model of the guard registers kept in the bench. Every bus write is paired with a check on the start pulses, so a stray pulse from any write is caught as well.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_LOCK   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_COMMIT = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_PROT   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_TEST   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_START  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_DONE   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_TLOCK  = 8'h18;

    localparam logic [15:0] TLOCK_KEY = 16'hA5A5;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LOCK,
        SEL_COMMIT,
        SEL_PROT,
        SEL_TEST,
        SEL_START,
        SEL_DONE,
        SEL_TLOCK
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    function automatic logic key_ok(input logic [DATA_W-1:0] d);
        return d[31:16] == TLOCK_KEY;
    endfunction

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_LOCK:   return SEL_LOCK;
            OFS_COMMIT: return SEL_COMMIT;
            OFS_PROT:   return SEL_PROT;
            OFS_TEST:   return SEL_TEST;
            OFS_START:  return SEL_START;
            OFS_DONE:   return SEL_DONE;
            OFS_TLOCK:  return SEL_TLOCK;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/memcfg_decode.sv
module memcfg_decode
    import memcfg_pkg::*;
(
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output bus_wr_t           wr
);
    reg_sel_e sel;

    always_comb begin
        sel     = decode_addr(bus_addr);
        wr.sel  = sel;
        wr.data = bus_wdata;
        // a write to an unmapped offset or the read-only mirror is dropped here
        wr.we   = bus_we && (sel != SEL_NONE) && (sel != SEL_DONE);
    end
endmodule

// File: rtl/memcfg_guard.sv
module memcfg_guard
    import memcfg_pkg::*;
#(
    parameter int NUM_REGIONS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  bus_wr_t                wr,
    output logic [NUM_REGIONS-1:0] soft_lock,
    output logic [NUM_REGIONS-1:0] commit,
    output logic [NUM_REGIONS-1:0] test_lock,
    output logic [NUM_REGIONS-1:0] blocked
);
    logic [NUM_REGIONS-1:0] wr_bits;
    assign wr_bits = wr.data[NUM_REGIONS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_lock <= '0;
            commit    <= '0;
            test_lock <= '0;
        end else if (wr.we) begin
            case (wr.sel)
                SEL_LOCK:   soft_lock <= wr_bits;
                SEL_COMMIT: commit    <= commit | wr_bits;
                SEL_TLOCK:  if (key_ok(wr.data)) test_lock <= wr_bits;
                default: ;
            endcase
        end
    end

    assign blocked = soft_lock | commit;

    // R3: a set commit bit never returns to 0 while out of reset
    assert_commit_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        ((commit & $past(commit)) == $past(commit)));

    // R4: the test-lock bits change only after a keyed write to their offset
    assert_tlock_key_R4: assert property (@(posedge clk) disable iff (rst)
        (test_lock != $past(test_lock)) |->
            $past(wr.we && wr.sel == SEL_TLOCK && wr.data[31:16] == 16'hA5A5));
endmodule

// File: rtl/memcfg_region.sv
module memcfg_region
    import memcfg_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  bus_wr_t   wr,
    input  logic      blocked,
    input  logic      test_locked,
    output logic      fetch_prot,
    output logic      wr_prot,
    output logic [1:0] test_mode,
    output logic      init_start
);
    localparam int FB = 2 * IDX;

    logic wr_ok;
    assign wr_ok = wr.we && !blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_prot <= 1'b0;
            wr_prot    <= 1'b0;
            test_mode  <= 2'b00;
            init_start <= 1'b0;
        end else begin
            init_start <= wr_ok && (wr.sel == SEL_START) && wr.data[IDX];
            if (wr_ok && wr.sel == SEL_PROT) begin
                fetch_prot <= wr.data[FB];
                wr_prot    <= wr.data[FB+1];
            end
            if (wr_ok && !test_locked && wr.sel == SEL_TEST)
                test_mode <= wr.data[FB +: 2];
        end
    end

    // R2: a locked or committed region keeps its protection field
    assert_prot_held_R2: assert property (@(posedge clk) disable iff (rst)
        blocked |=> $stable({wr_prot, fetch_prot}));

    // R5: a test-locked region keeps its test mode
    assert_test_held_R5: assert property (@(posedge clk) disable iff (rst)
        (test_locked || blocked) |=> $stable(test_mode));

    // R6: a start pulse only follows an accepted start write
    assert_start_cause_R6: assert property (@(posedge clk) disable iff (rst)
        init_start |-> $past(wr.we && wr.sel == SEL_START && !blocked));
endmodule

// File: rtl/memcfg_regbank.sv
module memcfg_regbank
    import memcfg_pkg::*;
#(
    parameter int NUM_REGIONS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [7:0]               bus_addr,
    input  logic                     bus_we,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [NUM_REGIONS-1:0]   init_done_i,
    output logic [NUM_REGIONS-1:0]   fetch_prot_o,
    output logic [NUM_REGIONS-1:0]   wr_prot_o,
    output logic [2*NUM_REGIONS-1:0] test_mode_o,
    output logic [NUM_REGIONS-1:0]   init_start_o
);
    localparam int FIELD_W = 2 * NUM_REGIONS;

    bus_wr_t                wr;
    logic [NUM_REGIONS-1:0] soft_lock, commit, test_lock, blocked;
    logic [FIELD_W-1:0]     prot_vec;

    memcfg_decode u_dec (
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .wr        (wr)
    );

    memcfg_guard #(.NUM_REGIONS(NUM_REGIONS)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .soft_lock (soft_lock),
        .commit    (commit),
        .test_lock (test_lock),
        .blocked   (blocked)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        memcfg_region #(.IDX(g)) u_region (
            .clk         (clk),
            .rst         (rst),
            .wr          (wr),
            .blocked     (blocked[g]),
            .test_locked (test_lock[g]),
            .fetch_prot  (fetch_prot_o[g]),
            .wr_prot     (wr_prot_o[g]),
            .test_mode   (test_mode_o[2*g +: 2]),
            .init_start  (init_start_o[g])
        );
        assign prot_vec[2*g]   = fetch_prot_o[g];
        assign prot_vec[2*g+1] = wr_prot_o[g];
    end

    always_comb begin
        case (wr.sel)
            SEL_LOCK:   bus_rdata = DATA_W'(soft_lock);
            SEL_COMMIT: bus_rdata = DATA_W'(commit);
            SEL_PROT:   bus_rdata = DATA_W'(prot_vec);
            SEL_TEST:   bus_rdata = DATA_W'(test_mode_o);
            SEL_DONE:   bus_rdata = DATA_W'(init_done_i);
            SEL_TLOCK:  bus_rdata = DATA_W'(test_lock);
            default:    bus_rdata = '0;
        endcase
    end

    // R8: unmapped offsets always read zero
    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (decode_addr(bus_addr) == SEL_NONE) |-> (bus_rdata == '0));

    // R7: the mirror offset follows the completion inputs
    assert_done_mirror_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 8'h14) |-> (bus_rdata[NUM_REGIONS-1:0] == init_done_i));
endmodule

// File: tb/sim_memcfg_regbank.sv
module sim_memcfg_regbank;
    localparam int N = 4;
    localparam logic [7:0] A_LOCK = 8'h00, A_COMMIT = 8'h04, A_PROT = 8'h08,
                           A_TEST = 8'h0C, A_START = 8'h10, A_DONE = 8'h14,
                           A_TLOCK = 8'h18;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [7:0]     bus_addr = '0;
    logic           bus_we = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [N-1:0]   init_done_i = '0;
    logic [N-1:0]   fetch_prot_o, wr_prot_o, init_start_o;
    logic [2*N-1:0] test_mode_o;

    always #4 clk = ~clk;

    memcfg_regbank #(.NUM_REGIONS(N)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .init_done_i(init_done_i),
        .fetch_prot_o(fetch_prot_o), .wr_prot_o(wr_prot_o),
        .test_mode_o(test_mode_o), .init_start_o(init_start_o)
    );

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sbq[$];

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    logic [N-1:0]   m_lock = '0, m_commit = '0, m_tlock = '0;
    logic [2*N-1:0] m_prot = '0, m_test = '0;

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            A_LOCK:   return 32'(m_lock);
            A_COMMIT: return 32'(m_commit);
            A_PROT:   return 32'(m_prot);
            A_TEST:   return 32'(m_test);
            A_DONE:   return 32'(init_done_i);
            A_TLOCK:  return 32'(m_tlock);
            default:  return 32'h0;
        endcase
    endfunction

    task automatic push(input int k, input logic [31:0] e, input string r);
        item_t it;
        it.kind = k; it.exp = e; it.req = r;
        sbq.push_back(it);
    endtask

    task automatic rd(input logic [7:0] a, input string r);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        push(0, model_read(a), r);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [N-1:0] blk;
        logic [N-1:0] pulse;
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        blk   = m_lock | m_commit;
        pulse = '0;
        case (a)
            A_LOCK:   m_lock = d[N-1:0];
            A_COMMIT: m_commit = m_commit | d[N-1:0];
            A_PROT:   for (int i = 0; i < N; i++)
                          if (!blk[i]) m_prot[2*i +: 2] = d[2*i +: 2];
            A_TEST:   for (int i = 0; i < N; i++)
                          if (!blk[i] && !m_tlock[i]) m_test[2*i +: 2] = d[2*i +: 2];
            A_START:  pulse = d[N-1:0] & ~blk;
            A_TLOCK:  if (d[31:16] == 16'hA5A5) m_tlock = d[N-1:0];
            default: ;
        endcase
        push(1, 32'(pulse), "R6");
    endtask

    task automatic idle_chk(input int k, input string r);
        @(negedge clk);
        bus_we = 1'b0;
        push(k, (k == 2) ? 32'(m_test) : 32'h0, r);
    endtask

    // monitor: samples two ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sbq.pop_front();
                case (it.kind)
                    0: act = bus_rdata;
                    1: act = 32'(init_start_o);
                    default: act = 32'(test_mode_o);
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd(A_LOCK, "R1"); rd(A_COMMIT, "R1"); rd(A_PROT, "R1");
        rd(A_TEST, "R1"); rd(A_TLOCK, "R1"); idle_chk(1, "R1");
        // R2 / R9: free writes land
        wr(A_PROT, 32'hFF); rd(A_PROT, "R9");
        wr(A_TEST, 32'h1B); rd(A_TEST, "R9");
        // R2: soft lock on region 1
        wr(A_LOCK, 32'h2); rd(A_LOCK, "R2");
        wr(A_PROT, 32'h00); rd(A_PROT, "R2");
        wr(A_TEST, 32'hFF); rd(A_TEST, "R2");
        wr(A_START, 32'hF); idle_chk(1, "R6"); rd(A_START, "R6");
        wr(A_LOCK, 32'h0); wr(A_PROT, 32'h00); rd(A_PROT, "R2");
        // R3: commit region 2
        wr(A_PROT, 32'h30); wr(A_COMMIT, 32'h4); rd(A_COMMIT, "R3");
        wr(A_COMMIT, 32'h0); rd(A_COMMIT, "R3");
        wr(A_PROT, 32'h0F); rd(A_PROT, "R3");
        wr(A_TEST, 32'h00); rd(A_TEST, "R3");
        wr(A_LOCK, 32'h4); wr(A_LOCK, 32'h0); wr(A_START, 32'h4); rd(A_PROT, "R3");
        // R4: keyed test lock
        wr(A_TLOCK, 32'h1234_0001); rd(A_TLOCK, "R4");
        wr(A_TLOCK, 32'hA5A5_0001); rd(A_TLOCK, "R4");
        wr(A_TLOCK, 32'h0000_0000); rd(A_TLOCK, "R4");
        // R5: test-lock guards only test mode
        wr(A_TEST, 32'hFF); rd(A_TEST, "R5"); idle_chk(2, "R5");
        wr(A_PROT, 32'h03); rd(A_PROT, "R5");
        // R7: completion mirror
        init_done_i = 4'hA; rd(A_DONE, "R7");
        wr(A_DONE, 32'hF); rd(A_DONE, "R7");
        // R8: unmapped and reserved bits
        wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, "R8"); rd(8'h1C, "R8");
        wr(8'h01, 32'h0F); rd(A_LOCK, "R8");
        wr(A_LOCK, 32'hFFFF_FFFF); rd(A_LOCK, "R8");
        wr(A_START, 32'hF); idle_chk(1, "R6");
        // R1 / R3: reset clears the commit
        @(negedge clk); bus_we = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_lock = '0; m_commit = '0; m_tlock = '0; m_prot = '0; m_test = '0;
        rd(A_COMMIT, "R3"); rd(A_PROT, "R1");
        wr(A_PROT, 32'hFF); rd(A_PROT, "R3");
        idle_chk(1, "R6");
        repeat (3) @(negedge clk);
        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule